// File: doc/BRIEF.md
# Dword-Only Register Access Slave

This block is the host-facing register file of a network controller. A host issues single 32-bit read or write cycles over a small valid/ready register bus. Each cycle carries a byte address and four byte enables. The slave holds these registers:

- a control register, whose low field drives the controller;
- an interrupt mask;
- a read-to-clear interrupt cause register, set by event pulses;
- a six-byte station address stored as two dwords;
- a set of 64-bit statistics counters, each seen as a low dword and a high dword.

The slave enforces whole-dword access. A write is only accepted when all four byte enables are set. Any other write is dropped and changes no state at all. A read always returns and consumes the entire dword, whatever the byte enables say. Because of this, even a one-byte read of the cause register clears all of its bits. Undeclared addresses, reserved bits and read-only fields all have a fixed, known behaviour, so software sees deterministic values.

Top module: `dword_reg_slave`

## Requirements
- R1: After reset the registers read as follows:
  - control reads 0x0000_3000;
  - mask, cause, both station-address dwords and every counter dword read 0;
  - `rsp_ready` is 0.
- R2: A write updates state only when `req_be` is 4'hF. A write with any other byte-enable pattern leaves every register unchanged.
- R3: A read returns all 32 bits of the addressed register, whatever the value of `req_be`.
- R4: Read-only and reserved fields are fixed:
  - control bits [15:12] always read 4'h3 and cannot be written;
  - control bits [31:16] read 0;
  - mask bits [31:8] read 0;
  - station-high bits [31:16] read 0;
  - writes to these fields have no effect.
- R5: Any accepted read of the cause register (offset 0x08) returns its current bits and clears them all, including a read with partial byte enables. Writes to the cause register have no effect.
- R6: A cause event arriving in the same cycle as a clearing read of the cause register is still set after the read. The read itself returns the value held before the event.
- R7: Counter k has its low dword at 0x40+8k and its high dword at 0x44+8k. Each `cnt_evt[k]` pulse adds one to the 64-bit value, carrying from the low dword into the high dword. Full-dword writes load either half.
- R8: A counter that holds all ones stays at all ones on further event pulses instead of wrapping.
- R9: The station address is stored in two dwords, and `mac_addr` presents it in wire order. Wire bytes 0..3 sit in byte lanes 0..3 of the low dword (offset 0x10). Wire bytes 4 and 5 sit in lanes 0 and 1 of the high dword (offset 0x14). `mac_addr[47:40]` carries wire byte 0 and `mac_addr[7:0]` carries wire byte 5.
- R10: Reads of undeclared addresses return 0, and writes to them change nothing. Undeclared addresses include any address whose low two bits are not 00.
- R11: An accepted request (`req_valid` high while `rsp_ready` is low) produces `rsp_ready` high for exactly one cycle, in the cycle after acceptance, with read data on `rsp_rdata`.
- R12: `irq` is high exactly when some cause bit is set whose mask bit (mask register, offset 0x04) is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| cause_evt | input | NUM_CAUSE | Event pulses that set cause bits |
| cnt_evt | input | NUM_CNT | Event pulses that increment counters |
| irq | output | 1 | Masked interrupt request |
| ctrl_out | output | 12 | Writable control field |
| mac_addr | output | 48 | Station address, first wire byte in the top byte |

## Verification
Two situations are hard to reach from the ports.

The first is a cause event landing in the very cycle a clearing read is accepted. The bench reaches it by driving the event pulse together with `req_valid` on a narrow-byte read of the cause register.

The second is counter saturation. It would take 2^64 event pulses to reach, so the bench preloads both counter halves with full-dword writes and then pulses. Random traffic mixes partial and full byte enables over declared and undeclared addresses. It checks every read against a bench model.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    localparam int DW       = 32;
    localparam int BE_W     = DW / 8;
    localparam int CTRL_W   = 12;
    localparam logic [3:0] CTRL_REV = 4'h3;
    localparam int STA_HI_W = 16;
    localparam int MAC_W    = 48;
    localparam int MAC_BYTES = MAC_W / 8;
    localparam int CNT_W    = 64;

    localparam logic [7:0] OFF_CTRL     = 8'h00;
    localparam logic [7:0] OFF_IMASK    = 8'h04;
    localparam logic [7:0] OFF_CAUSE    = 8'h08;
    localparam logic [7:0] OFF_STA_LO   = 8'h10;
    localparam logic [7:0] OFF_STA_HI   = 8'h14;
    localparam logic [7:0] OFF_CNT_BASE = 8'h40;
    localparam int CNT_STRIDE = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_IMASK,
        SEL_CAUSE,
        SEL_STA_LO,
        SEL_STA_HI,
        SEL_CNT_LO,
        SEL_CNT_HI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    function automatic logic full_dword(input logic [BE_W-1:0] be);
        return &be;
    endfunction

    // byte i of the stored pair lands at the i-th byte from the top
    function automatic logic [MAC_W-1:0] to_wire_order(input logic [DW-1:0] lo,
                                                       input logic [STA_HI_W-1:0] hi);
        logic [MAC_W-1:0] flat;
        logic [MAC_W-1:0] r;
        flat = {hi, lo};
        r = '0;
        for (int i = 0; i < MAC_BYTES; i++) begin
            r[MAC_W-8-8*i +: 8] = flat[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/regslv_decode.sv
module regslv_decode
    import regslv_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int CNT_SPAN = NUM_CNT * CNT_STRIDE;

    logic [ADDR_W-1:0] cnt_off;
    logic              in_cnt;

    assign cnt_off = addr - ADDR_W'(OFF_CNT_BASE);
    assign in_cnt  = (addr >= ADDR_W'(OFF_CNT_BASE)) &&
                     (addr <  ADDR_W'(OFF_CNT_BASE + CNT_SPAN));

    always_comb begin
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(OFF_CTRL))        sel.kind = SEL_CTRL;
            else if (addr == ADDR_W'(OFF_IMASK))  sel.kind = SEL_IMASK;
            else if (addr == ADDR_W'(OFF_CAUSE))  sel.kind = SEL_CAUSE;
            else if (addr == ADDR_W'(OFF_STA_LO)) sel.kind = SEL_STA_LO;
            else if (addr == ADDR_W'(OFF_STA_HI)) sel.kind = SEL_STA_HI;
            else if (in_cnt) begin
                sel.kind = cnt_off[2] ? SEL_CNT_HI : SEL_CNT_LO;
                sel.idx  = 8'(cnt_off >> 3);
            end
        end
    end

endmodule

// File: rtl/regslv_cause.sv
module regslv_cause #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] cause,
    output logic         irq
);

    logic [N-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q <= (clr ? '0 : cause_q) | evt;
        end
    end

    assign cause = cause_q;
    assign irq   = |(cause_q & mask);

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !(|evt)) |=> (cause_q == '0)); // R5

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((cause_q & $past(evt)) == $past(evt))); // R6

    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(|evt)) |=> $stable(cause_q)); // R5

endmodule

// File: rtl/regslv_counter.sv
module regslv_counter
    import regslv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wdata,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] val_q;
    logic             at_max;

    assign at_max = &val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) val_q[DW-1:0]     <= wdata;
            if (wr_hi) val_q[CNT_W-1:DW] <= wdata;
        end else if (inc && !at_max) begin
            val_q <= val_q + 1'b1;
        end
    end

    assign value = val_q;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((&val_q) && !wr_lo && !wr_hi) |=> (&val_q)); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_lo && !wr_hi && !(&val_q)) |=> (val_q == $past(val_q) + 64'd1)); // R7

endmodule

// File: rtl/dword_reg_slave.sv
module dword_reg_slave
    import regslv_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CAUSE = 8,
    parameter int NUM_CNT   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BE_W-1:0]      req_be,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_ready,
    output logic [DW-1:0]        rsp_rdata,
    input  logic [NUM_CAUSE-1:0] cause_evt,
    input  logic [NUM_CNT-1:0]   cnt_evt,
    output logic                 irq,
    output logic [CTRL_W-1:0]    ctrl_out,
    output logic [MAC_W-1:0]     mac_addr
);

    reg_sel_t sel;
    logic     accept;
    logic     wr_ok;
    logic     rd_cause;

    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_CAUSE-1:0] mask_q;
    logic [DW-1:0]        sta_lo_q;
    logic [STA_HI_W-1:0]  sta_hi_q;
    logic [NUM_CAUSE-1:0] cause_v;
    logic [CNT_W-1:0]     cnt_val [NUM_CNT];
    logic [DW-1:0]        rd_mux;
    logic                 ready_q;
    logic [DW-1:0]        rdata_q;

    regslv_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CNT (NUM_CNT)
    ) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    assign accept   = req_valid && !ready_q;
    assign wr_ok    = accept && req_write && full_dword(req_be);
    assign rd_cause = accept && !req_write && (sel.kind == SEL_CAUSE);

    // plain control, mask and station-address storage
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            mask_q   <= '0;
            sta_lo_q <= '0;
            sta_hi_q <= '0;
        end else if (wr_ok) begin
            case (sel.kind)
                SEL_CTRL:   ctrl_q   <= req_wdata[CTRL_W-1:0];
                SEL_IMASK:  mask_q   <= req_wdata[NUM_CAUSE-1:0];
                SEL_STA_LO: sta_lo_q <= req_wdata;
                SEL_STA_HI: sta_hi_q <= req_wdata[STA_HI_W-1:0];
                default: ;
            endcase
        end
    end

    regslv_cause #(
        .N (NUM_CAUSE)
    ) u_cause (
        .clk   (clk),
        .rst   (rst),
        .evt   (cause_evt),
        .clr   (rd_cause),
        .mask  (mask_q),
        .cause (cause_v),
        .irq   (irq)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        logic hit;
        assign hit = wr_ok && (sel.idx == 8'(k));
        regslv_counter u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_evt[k]),
            .wr_lo (hit && (sel.kind == SEL_CNT_LO)),
            .wr_hi (hit && (sel.kind == SEL_CNT_HI)),
            .wdata (req_wdata),
            .value (cnt_val[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            SEL_CTRL:   rd_mux = {16'h0, CTRL_REV, ctrl_q};
            SEL_IMASK:  rd_mux = DW'(mask_q);
            SEL_CAUSE:  rd_mux = DW'(cause_v);
            SEL_STA_LO: rd_mux = sta_lo_q;
            SEL_STA_HI: rd_mux = DW'(sta_hi_q);
            SEL_CNT_LO, SEL_CNT_HI: begin
                for (int k = 0; k < NUM_CNT; k++) begin
                    if (sel.idx == 8'(k)) begin
                        rd_mux = (sel.kind == SEL_CNT_HI) ? cnt_val[k][CNT_W-1:DW]
                                                          : cnt_val[k][DW-1:0];
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= accept;
            if (accept) begin
                rdata_q <= req_write ? '0 : rd_mux;
            end
        end
    end

    assign rsp_ready = ready_q;
    assign rsp_rdata = rdata_q;
    assign ctrl_out  = ctrl_q;
    assign mac_addr  = to_wire_order(sta_lo_q, sta_hi_q);

    AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready); // R11

    AST_RDY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> $past(req_valid)); // R11

    AST_PARTIAL_WR_INERT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_ready && req_write && !(&req_be)) |=>
        ($stable(ctrl_q) && $stable(mask_q) && $stable(sta_lo_q) && $stable(sta_hi_q))); // R2

    AST_CTRL_RO_FIELD: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && $past(sel.kind == SEL_CTRL && !req_write)) |->
        (rsp_rdata[31:16] == 16'h0 && rsp_rdata[15:12] == CTRL_REV)); // R4

    AST_UNDECL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && $past(sel.kind == SEL_NONE)) |-> (rsp_rdata == '0)); // R10

endmodule

// File: tb/tb_dword_reg_slave.sv
module tb_dword_reg_slave;
    import regslv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NUM_CAUSE  = 8;
    localparam int NUM_CNT    = 4;
    localparam int WATCHDOG   = 100000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [ADDR_W-1:0]    req_addr  = '0;
    logic [3:0]           req_be    = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_ready;
    logic [31:0]          rsp_rdata;
    logic [NUM_CAUSE-1:0] cause_evt = '0;
    logic [NUM_CNT-1:0]   cnt_evt   = '0;
    logic                 irq;
    logic [11:0]          ctrl_out;
    logic [47:0]          mac_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dword_reg_slave #(
        .ADDR_W    (ADDR_W),
        .NUM_CAUSE (NUM_CAUSE),
        .NUM_CNT   (NUM_CNT)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .cause_evt (cause_evt),
        .cnt_evt   (cnt_evt),
        .irq       (irq),
        .ctrl_out  (ctrl_out),
        .mac_addr  (mac_addr)
    );

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    // bench model
    logic [11:0] m_ctrl   = '0;
    logic [7:0]  m_mask   = '0;
    logic [7:0]  m_cause  = '0;
    logic [31:0] m_sta_lo = '0;
    logic [15:0] m_sta_hi = '0;
    logic [63:0] m_cnt [NUM_CNT];

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_cnt(input logic [7:0] a);
        return (a >= 8'h40) && (a < 8'h60) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int k;
        case (a)
            8'h00: return {16'h0, 4'h3, m_ctrl};
            8'h04: return {24'h0, m_mask};
            8'h08: return {24'h0, m_cause};
            8'h10: return m_sta_lo;
            8'h14: return {16'h0, m_sta_hi};
            default: begin
                if (is_cnt(a)) begin
                    k = int'((a - 8'h40) >> 3);
                    return a[2] ? m_cnt[k][63:32] : m_cnt[k][31:0];
                end
                return 32'h0;
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h08) return "R5";
        if (a == 8'h00 || a == 8'h04 || a == 8'h10 || a == 8'h14) return "R3";
        if (is_cnt(a)) return "R7";
        return "R10";
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        int k;
        if (be != 4'hF) return;
        case (a)
            8'h00: m_ctrl   = d[11:0];
            8'h04: m_mask   = d[7:0];
            8'h10: m_sta_lo = d;
            8'h14: m_sta_hi = d[15:0];
            default: begin
                if (is_cnt(a)) begin
                    k = int'((a - 8'h40) >> 3);
                    if (a[2]) m_cnt[k][63:32] = d;
                    else      m_cnt[k][31:0]  = d;
                end
            end
        endcase
    endtask

    // entered and left at a falling edge
    task automatic access(input logic wr, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [7:0] evt,
                          output logic [31:0] rd);
        check("R11", "ready idle before request", 64'(rsp_ready), 64'd0);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_be    = be;
        req_wdata = d;
        cause_evt = evt;
        @(posedge clk);
        @(negedge clk);
        cause_evt = '0;
        check("R11", "ready one cycle after accept", 64'(rsp_ready), 64'd1);
        rd = rsp_rdata;
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11", "ready is a single pulse", 64'(rsp_ready), 64'd0);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] rd;
        access(1'b1, a, be, d, 8'h0, rd);
        model_write(a, be, d);
    endtask

    task automatic do_read(input string tag, input logic [7:0] a, input logic [3:0] be,
                           input logic [7:0] evt);
        logic [31:0] rd;
        logic [31:0] exp;
        exp = exp_read(a);
        access(1'b0, a, be, 32'h0, evt, rd);
        if (a == 8'h08) m_cause = evt;
        else            m_cause = m_cause | evt;
        check(tag, $sformatf("read addr %h be %h", a, be), 64'(rd), 64'(exp));
    endtask

    task automatic pulse_cause(input logic [7:0] v);
        cause_evt = v;
        @(posedge clk);
        @(negedge clk);
        cause_evt = '0;
        m_cause = m_cause | v;
    endtask

    task automatic pulse_cnt(input logic [NUM_CNT-1:0] v);
        cnt_evt = v;
        @(posedge clk);
        @(negedge clk);
        cnt_evt = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (v[k] && m_cnt[k] != 64'hFFFF_FFFF_FFFF_FFFF) m_cnt[k] = m_cnt[k] + 64'd1;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    logic [7:0] addr_pool [16];

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED_0042);
        for (int k = 0; k < NUM_CNT; k++) m_cnt[k] = 64'h0;
        addr_pool = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h40,
                      8'h44, 8'h48, 8'h4C, 8'h58, 8'h5C, 8'h60, 8'h12, 8'hFC};

        repeat (3) @(negedge clk);
        check("R1", "ready low in reset", 64'(rsp_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        do_read("R1", 8'h00, 4'hF, 8'h0);
        check("R1", "control reset literal", 64'(exp_read(8'h00)), 64'h0000_3000);
        do_read("R1", 8'h04, 4'hF, 8'h0);
        do_read("R1", 8'h08, 4'hF, 8'h0);
        do_read("R1", 8'h10, 4'hF, 8'h0);
        do_read("R1", 8'h14, 4'hF, 8'h0);
        do_read("R1", 8'h5C, 4'hF, 8'h0);
        check("R1", "irq low after reset", 64'(irq), 64'd0);

        // R2 partial writes dropped, full write lands
        do_write(8'h00, 4'h7, 32'hFFFF_FFFF);
        do_read("R2", 8'h00, 4'hF, 8'h0);
        do_write(8'h10, 4'h1, 32'hDEAD_BEEF);
        do_read("R2", 8'h10, 4'hF, 8'h0);
        do_write(8'h40, 4'hE, 32'h1234_5678);
        do_read("R2", 8'h40, 4'hF, 8'h0);
        do_write(8'h00, 4'hF, 32'hFFFF_FABC);
        check("R2", "ctrl_out after full write", 64'(ctrl_out), 64'hABC);

        // R4 read-only / reserved fields
        do_read("R4", 8'h00, 4'hF, 8'h0);
        do_write(8'h04, 4'hF, 32'hFFFF_FF05);
        do_read("R4", 8'h04, 4'hF, 8'h0);

        // R3 narrow reads still return full dword
        do_read("R3", 8'h00, 4'h1, 8'h0);
        do_read("R3", 8'h00, 4'h0, 8'h0);

        // R9 station address byte order
        do_write(8'h10, 4'hF, 32'h4433_2211);
        do_write(8'h14, 4'hF, 32'hABCD_6655);
        check("R9", "mac_addr wire order", 64'(mac_addr), 64'h1122_3344_5566);
        do_read("R4", 8'h14, 4'hF, 8'h0);

        // R12 masked interrupt (mask = 0x05)
        pulse_cause(8'h02);
        check("R12", "irq with unmasked bit only", 64'(irq), 64'd0);
        pulse_cause(8'h04);
        check("R12", "irq with masked bit set", 64'(irq), 64'd1);

        // R5 partial read clears everything; writes ignored
        do_write(8'h08, 4'hF, 32'h0000_00FF);
        do_read("R5", 8'h08, 4'h2, 8'h0);
        do_read("R5", 8'h08, 4'hF, 8'h0);
        check("R12", "irq low after clearing read", 64'(irq), 64'd0);

        // R6 event coincides with clearing read
        pulse_cause(8'h03);
        do_read("R6", 8'h08, 4'h1, 8'h10);
        do_read("R6", 8'h08, 4'hF, 8'h0);
        do_read("R6", 8'h08, 4'hF, 8'h0);

        // R7 increment and carry across the pair
        pulse_cnt(4'b0010);
        pulse_cnt(4'b0010);
        do_read("R7", 8'h48, 4'hF, 8'h0);
        do_read("R7", 8'h4C, 4'hF, 8'h0);
        do_write(8'h50, 4'hF, 32'hFFFF_FFFF);
        do_write(8'h54, 4'hF, 32'h0000_0007);
        pulse_cnt(4'b0100);
        do_read("R7", 8'h50, 4'hF, 8'h0);
        do_read("R7", 8'h54, 4'hF, 8'h0);
        check("R7", "carry into high dword", 64'(m_cnt[2]), 64'h0000_0008_0000_0000);

        // R8 saturation
        do_write(8'h58, 4'hF, 32'hFFFF_FFFE);
        do_write(8'h5C, 4'hF, 32'hFFFF_FFFF);
        pulse_cnt(4'b1000);
        pulse_cnt(4'b1000);
        pulse_cnt(4'b1000);
        do_read("R8", 8'h58, 4'hF, 8'h0);
        do_read("R8", 8'h5C, 4'hF, 8'h0);

        // R10 undeclared addresses
        do_write(8'h0C, 4'hF, 32'h1111_1111);
        do_write(8'h12, 4'hF, 32'h2222_2222);
        do_read("R10", 8'h0C, 4'hF, 8'h0);
        do_read("R10", 8'h12, 4'hF, 8'h0);
        do_read("R10", 8'h60, 4'hF, 8'h0);
        do_read("R10", 8'h10, 4'hF, 8'h0);

        // constrained random traffic
        for (int it = 0; it < 400; it++) begin
            logic [7:0]  a;
            logic [3:0]  be;
            logic [31:0] d;
            logic [7:0]  evt;
            a   = addr_pool[$urandom_range(0, 15)];
            be  = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom_range(0, 15));
            d   = $urandom();
            evt = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0;
            if ($urandom_range(0, 2) == 0) begin
                pulse_cnt(4'($urandom_range(0, 15)));
            end
            if ($urandom_range(0, 1) == 0) begin
                do_write(a, be, d);
                m_cause = m_cause;
            end else begin
                do_read(tag_of(a), a, be, evt);
            end
            checks++;
            if (irq !== |(m_cause & m_mask)) begin
                failures++;
                $display("FAIL R12 irq actual=%b expected=%b", irq, |(m_cause & m_mask));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule